// File: doc/BRIEF.md
# Frame-Paced Two-Class Transaction Request Scheduler

This block sits between software and a host-side transaction engine. Software posts transaction requests into one of two in-order request queues. The time-critical queue carries isochronous and interrupt work. The best-effort queue carries control and bulk work. Each request holds a direction, a channel number and a small attribute field.

A frame timer marks the open window of each frame with a start pulse and an end pulse. Inside that window the scheduler offers one request at a time to the downstream engine, always taking the time-critical queue before the best-effort one. A request leaves its queue only when the engine reports that the transaction has finished. Each queue reports its free-entry count. A time-critical request that is still queued when the frame closes sets a sticky incomplete flag. That request stays queued and is offered first in the next frame.

Top module: `frame_txn_sched`

## Requirements
- R1: After a synchronous reset, both free counts equal DEPTH (8), `iss_valid` is low, and `per_ovf`, `np_ovf` and `incomp_per` are low.
- R2: A push (`push_valid` high; `push_periodic` 1 selects the time-critical queue and 0 the best-effort queue) lowers that queue's free count by one on the next cycle. A push into a queue whose free count is 0 is dropped, even if a pop happens in the same cycle. A dropped push leaves the count at 0 and sets that queue's sticky overflow flag.
- R3: Requests within a queue are offered in the order they were pushed. The offered payload (`iss_dir`, with 1 = IN and 0 = OUT, `iss_chan`, `iss_attr`) matches the pushed request.
- R4: When the scheduler picks a new request, it takes the time-critical queue whenever that queue is non-empty. A best-effort request is picked only when the time-critical free count is DEPTH. `iss_periodic` shows which queue the offer comes from (1 = time-critical).
- R5: Requests are offered only inside a frame window, which opens one cycle after `frame_start` and closes at `frame_end`. An offer is picked two cycles after `frame_start` at the earliest. While it is not accepted, `iss_valid` and the payload hold steady until `iss_ready` is high.
- R6: After acceptance (`iss_valid` and `iss_ready` both high), the request is removed from its queue in the cycle `iss_done` is high. The free count rises on the next cycle, and the next offer can follow one cycle after that. `iss_done` has no effect when no transaction is in flight.
- R7: If the time-critical queue is non-empty in the cycle `frame_end` is high, `incomp_per` is set on the next cycle. It stays set until an `incomp_clr` pulse clears it. A set and a clear in the same cycle leave it set.
- R8: Time-critical requests left at the end of a frame stay queued and are offered first in the next frame.
- R9: A `frame_end` that arrives while an offer is not accepted withdraws it, and `iss_valid` is low on the next cycle. A transaction already in flight still completes on `iss_done` after the frame closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse that opens a frame window |
| frame_end | input | 1 | Pulse that closes the frame window |
| incomp_clr | input | 1 | Write-one-to-clear pulse for `incomp_per` |
| push_valid | input | 1 | Push a request this cycle |
| push_periodic | input | 1 | 1 = time-critical queue, 0 = best-effort queue |
| push_dir | input | 1 | Request direction, 1 = IN, 0 = OUT |
| push_chan | input | 4 | Request channel number |
| push_attr | input | 3 | Request attribute bits |
| iss_valid | output | 1 | Offer to the downstream engine is valid |
| iss_periodic | output | 1 | Offer comes from the time-critical queue |
| iss_dir | output | 1 | Offered direction |
| iss_chan | output | 4 | Offered channel |
| iss_attr | output | 3 | Offered attributes |
| iss_ready | input | 1 | Engine accepts the offer |
| iss_done | input | 1 | Engine has finished the accepted transaction |
| per_free | output | 4 | Free entries in the time-critical queue (0..8) |
| np_free | output | 4 | Free entries in the best-effort queue (0..8) |
| per_ovf | output | 1 | Sticky overflow flag, time-critical queue |
| np_ovf | output | 1 | Sticky overflow flag, best-effort queue |
| incomp_per | output | 1 | Sticky incomplete time-critical status |

## Verification
The block is first driven with both queues loaded before any frame opens. This shows that the time-critical queue wins and that its ninth push is dropped. A deliberately short frame then leaves time-critical work behind, which tells the incomplete flag and carry-over into the next frame apart from a simple drain. A long random run mixes pushes to both queues, sparse and back-to-back engine handshakes, frames whose start and end pulses coincide, and clear pulses. This run separates correct ordering and counting from near misses, such as picking best-effort work while time-critical entries wait. Short directed steps cover an offer withdrawn at frame end and a done pulse with nothing in flight.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int CHAN_W = 4;
    localparam int ATTR_W = 3;
    localparam int NUM_Q  = 2;
    localparam int Q_PER  = 0;
    localparam int Q_NP   = 1;

    typedef struct packed {
        logic              is_in;
        logic [CHAN_W-1:0] chan;
        logic [ATTR_W-1:0] attr;
    } txn_req_t;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_OFFER = 2'd1,
        ARB_BUSY  = 2'd2
    } arb_state_e;

    function automatic txn_req_t make_req(input logic dir,
                                          input logic [CHAN_W-1:0] ch,
                                          input logic [ATTR_W-1:0] at);
        txn_req_t r;
        r.is_in = dir;
        r.chan  = ch;
        r.attr  = at;
        return r;
    endfunction

endpackage

// File: rtl/req_fifo.sv
module req_fifo
    import sched_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_en,
    input  txn_req_t         push_data,
    input  logic             pop_en,
    output txn_req_t         head,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);

    txn_req_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, accept, take;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full   = (count == CNT_W'(DEPTH));
    assign accept = push_en && !full;
    assign take   = pop_en && (count != '0);
    assign head   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (take)   rd_ptr <= bump(rd_ptr);
            case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push_en && full) overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/frame_tracker.sv
module frame_tracker (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic frame_end,
    input  logic per_pending,
    input  logic incomp_clr,
    output logic in_frame,
    output logic incomp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            incomp   <= 1'b0;
        end else begin
            if (frame_start)    in_frame <= 1'b1;
            else if (frame_end) in_frame <= 1'b0;

            if (frame_end && per_pending) incomp <= 1'b1;
            else if (incomp_clr)          incomp <= 1'b0;
        end
    end

endmodule

// File: rtl/sched_arbiter.sv
module sched_arbiter
    import sched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_frame,
    input  logic frame_end,
    input  logic per_avail,
    input  logic np_avail,
    input  logic iss_ready,
    input  logic iss_done,
    output logic offer,
    output logic sel_per,
    output logic pop_per,
    output logic pop_np
);

    arb_state_e state, nxt;

    always_comb begin
        nxt = state;
        case (state)
            ARB_IDLE:
                if (in_frame && !frame_end && (per_avail || np_avail)) nxt = ARB_OFFER;
            ARB_OFFER:
                if (iss_ready)                   nxt = ARB_BUSY;
                else if (frame_end || !in_frame) nxt = ARB_IDLE;
            ARB_BUSY:
                if (iss_done) nxt = ARB_IDLE;
            default: nxt = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ARB_IDLE;
            sel_per <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ARB_IDLE && nxt == ARB_OFFER) sel_per <= per_avail;
        end
    end

    assign offer   = (state == ARB_OFFER);
    assign pop_per = (state == ARB_BUSY) && iss_done && sel_per;
    assign pop_np  = (state == ARB_BUSY) && iss_done && !sel_per;

endmodule

// File: rtl/frame_txn_sched.sv
module frame_txn_sched
    import sched_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        frame_start,
    input  logic                        frame_end,
    input  logic                        incomp_clr,
    input  logic                        push_valid,
    input  logic                        push_periodic,
    input  logic                        push_dir,
    input  logic [sched_pkg::CHAN_W-1:0] push_chan,
    input  logic [sched_pkg::ATTR_W-1:0] push_attr,
    output logic                        iss_valid,
    output logic                        iss_periodic,
    output logic                        iss_dir,
    output logic [sched_pkg::CHAN_W-1:0] iss_chan,
    output logic [sched_pkg::ATTR_W-1:0] iss_attr,
    input  logic                        iss_ready,
    input  logic                        iss_done,
    output logic [CNT_W-1:0]            per_free,
    output logic [CNT_W-1:0]            np_free,
    output logic                        per_ovf,
    output logic                        np_ovf,
    output logic                        incomp_per
);

    txn_req_t         req_in;
    txn_req_t         head_q  [NUM_Q];
    logic [CNT_W-1:0] count_q [NUM_Q];
    logic             push_q  [NUM_Q];
    logic             pop_q   [NUM_Q];
    logic             ovf_q   [NUM_Q];
    logic             in_frame, sel_per, pop_per, pop_np;
    txn_req_t         offered;

    assign req_in        = make_req(push_dir, push_chan, push_attr);
    assign push_q[Q_PER] = push_valid && push_periodic;
    assign push_q[Q_NP]  = push_valid && !push_periodic;
    assign pop_q[Q_PER]  = pop_per;
    assign pop_q[Q_NP]   = pop_np;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        req_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst      (rst),
            .push_en  (push_q[q]),
            .push_data(req_in),
            .pop_en   (pop_q[q]),
            .head     (head_q[q]),
            .count    (count_q[q]),
            .overflow (ovf_q[q])
        );
    end

    frame_tracker u_frame (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .per_pending(count_q[Q_PER] != '0),
        .incomp_clr (incomp_clr),
        .in_frame   (in_frame),
        .incomp     (incomp_per)
    );

    sched_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .in_frame (in_frame),
        .frame_end(frame_end),
        .per_avail(count_q[Q_PER] != '0),
        .np_avail (count_q[Q_NP] != '0),
        .iss_ready(iss_ready),
        .iss_done (iss_done),
        .offer    (iss_valid),
        .sel_per  (sel_per),
        .pop_per  (pop_per),
        .pop_np   (pop_np)
    );

    assign offered      = sel_per ? head_q[Q_PER] : head_q[Q_NP];
    assign iss_periodic = sel_per;
    assign iss_dir      = offered.is_in;
    assign iss_chan     = offered.chan;
    assign iss_attr     = offered.attr;
    assign per_free     = CNT_W'(DEPTH) - count_q[Q_PER];
    assign np_free      = CNT_W'(DEPTH) - count_q[Q_NP];
    assign per_ovf      = ovf_q[Q_PER];
    assign np_ovf       = ovf_q[Q_NP];

endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        frame_end,
    input logic                        iss_valid,
    input logic                        iss_ready,
    input logic                        iss_periodic,
    input logic                        iss_dir,
    input logic [sched_pkg::CHAN_W-1:0] iss_chan,
    input logic [sched_pkg::ATTR_W-1:0] iss_attr,
    input logic [CNT_W-1:0]            per_free,
    input logic [CNT_W-1:0]            np_free,
    input logic                        per_ovf,
    input logic                        np_ovf,
    input logic                        incomp_per
);

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (per_free <= CNT_W'(DEPTH)) && (np_free <= CNT_W'(DEPTH))); // R2

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (per_ovf || np_ovf) |=> (per_ovf || np_ovf) && ($past(per_ovf) -> per_ovf)); // R2

    AST_NP_WAITS: assert property (@(posedge clk) disable iff (rst)
        ($rose(iss_valid) && !iss_periodic) |-> ($past(per_free) == CNT_W'(DEPTH))); // R4

    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready && !frame_end) |=>
            (iss_valid && $stable(iss_periodic) && $stable(iss_dir)
             && $stable(iss_chan) && $stable(iss_attr))); // R5

    AST_INCOMP_SET: assert property (@(posedge clk) disable iff (rst)
        (frame_end && per_free != CNT_W'(DEPTH)) |=> incomp_per); // R7

    AST_WITHDRAW: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready && frame_end) |=> !iss_valid); // R9

endmodule

bind frame_txn_sched sched_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_end   (frame_end),
    .iss_valid   (iss_valid),
    .iss_ready   (iss_ready),
    .iss_periodic(iss_periodic),
    .iss_dir     (iss_dir),
    .iss_chan    (iss_chan),
    .iss_attr    (iss_attr),
    .per_free    (per_free),
    .np_free     (np_free),
    .per_ovf     (per_ovf),
    .np_ovf      (np_ovf),
    .incomp_per  (incomp_per)
);

// File: tb/sim_frame_txn_sched.sv
`timescale 1ns/1ps
module sim_frame_txn_sched;
    import sched_pkg::*;

    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 0, frame_end = 0, incomp_clr = 0;
    logic push_valid = 0, push_periodic = 0, push_dir = 0;
    logic [CHAN_W-1:0] push_chan = '0;
    logic [ATTR_W-1:0] push_attr = '0;
    logic iss_ready = 0, iss_done = 0;
    logic iss_valid, iss_periodic, iss_dir;
    logic [CHAN_W-1:0] iss_chan;
    logic [ATTR_W-1:0] iss_attr;
    logic [CW-1:0] per_free, np_free;
    logic per_ovf, np_ovf, incomp_per;

    always #5 clk = ~clk;

    frame_txn_sched #(.DEPTH(DEPTH)) u0 (.*);

    // behavioural reference
    txn_req_t pq[$];
    txn_req_t nq[$];
    int  m_st = 0;
    bit  m_sel = 0, m_in = 0, m_inc = 0, m_povf = 0, m_novf = 0;
    int  checks = 0, fails = 0;
    int  ds_mode = 0;
    bit  done_flag = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic model_step();
        int pn, nn, st0;
        bit in0;
        txn_req_t e;
        if (rst) begin
            pq.delete(); nq.delete();
            m_st = 0; m_sel = 0; m_in = 0; m_inc = 0; m_povf = 0; m_novf = 0;
            return;
        end
        pn = pq.size(); nn = nq.size(); st0 = m_st; in0 = m_in;
        e = make_req(push_dir, push_chan, push_attr);
        if (push_valid) begin
            if (push_periodic) begin
                if (pn == DEPTH) m_povf = 1; else pq.push_back(e);
            end else begin
                if (nn == DEPTH) m_novf = 1; else nq.push_back(e);
            end
        end
        if (st0 == 2 && iss_done) begin
            if (m_sel) void'(pq.pop_front()); else void'(nq.pop_front());
        end
        case (st0)
            0: if (in0 && !frame_end && (pn > 0 || nn > 0)) begin m_st = 1; m_sel = (pn > 0); end
            1: if (iss_ready) m_st = 2; else if (frame_end || !in0) m_st = 0;
            default: if (iss_done) m_st = 0;
        endcase
        if (frame_end && pn > 0) m_inc = 1; else if (incomp_clr) m_inc = 0;
        if (frame_start) m_in = 1; else if (frame_end) m_in = 0;
    endtask

    task automatic compare();
        txn_req_t h;
        chk(per_free == CW'(DEPTH - pq.size()), "R2 per_free", per_free, DEPTH - pq.size());
        chk(np_free == CW'(DEPTH - nq.size()), "R2 np_free", np_free, DEPTH - nq.size());
        chk(per_ovf == m_povf, "R2 per_ovf", per_ovf, m_povf);
        chk(np_ovf == m_novf, "R2 np_ovf", np_ovf, m_novf);
        chk(incomp_per == m_inc, "R7 incomp_per", incomp_per, m_inc);
        chk(iss_valid == (m_st == 1), "R5 iss_valid", iss_valid, m_st == 1);
        if (m_st == 1 && iss_valid) begin
            h = m_sel ? pq[0] : nq[0];
            chk(iss_periodic == m_sel, "R4 iss_periodic", iss_periodic, m_sel);
            chk({iss_dir, iss_chan, iss_attr} == h, "R3 payload",
                {iss_dir, iss_chan, iss_attr}, h);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare();
        push_valid = 0; frame_start = 0; frame_end = 0; incomp_clr = 0;
        if (ds_mode != 0) begin
            iss_ready = iss_valid && (ds_mode == 1 || $urandom_range(1) == 1);
            iss_done  = (m_st == 2) && (ds_mode == 1 || $urandom_range(2) == 0);
        end
    endtask

    task automatic push(input bit per, input int tagv);
        push_valid = 1; push_periodic = per;
        push_dir = tagv[0]; push_chan = CHAN_W'(tagv >> 1); push_attr = ATTR_W'(tagv >> 3);
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int f0;
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk(per_free == CW'(DEPTH) && np_free == CW'(DEPTH), "R1 free after reset", per_free, DEPTH);
        chk(!iss_valid && !per_ovf && !np_ovf && !incomp_per, "R1 flags after reset", iss_valid, 0);

        // R2 overflow: nine time-critical pushes, three best-effort, no frame open
        for (int i = 0; i < 9; i++) push(1, i * 5 + 1);
        for (int i = 0; i < 3; i++) push(0, i * 7 + 2);
        chk(per_free == 0 && per_ovf, "R2 full queue drop", per_free, 0);
        chk(!iss_valid, "R5 no offer outside frame", iss_valid, 0);

        // short frame leaves time-critical work: R7, then R8 carry-over
        ds_mode = 1;
        frame_start = 1; tick();
        repeat (6) tick();
        frame_end = 1; tick();
        repeat (4) tick();
        chk(incomp_per == 1, "R7 incomplete set", incomp_per, 1);
        chk(per_free != CW'(DEPTH), "R8 entries retained", per_free, 0);
        incomp_clr = 1; tick();
        chk(incomp_per == 0, "R7 cleared by pulse", incomp_per, 0);
        frame_start = 1; tick();
        while (!iss_valid) tick();
        chk(iss_periodic == 1, "R8 periodic first in new frame", iss_periodic, 1);
        repeat (80) tick();
        frame_end = 1; tick();
        chk(per_free == CW'(DEPTH) && np_free == CW'(DEPTH), "R4 both drained", np_free, DEPTH);

        // R9 withdraw an unaccepted offer at frame end
        ds_mode = 0; iss_ready = 0; iss_done = 0;
        push(1, 9);
        frame_start = 1; tick();
        repeat (3) tick();
        chk(iss_valid == 1, "R9 offer present", iss_valid, 1);
        frame_end = 1; tick();
        chk(iss_valid == 0, "R9 offer withdrawn", iss_valid, 0);
        // R6 done with nothing in flight has no effect
        f0 = per_free;
        iss_done = 1; tick(); tick();
        iss_done = 0;
        chk(per_free == CW'(f0), "R6 stray done ignored", per_free, f0);
        // R6 accept in flight, complete after frame closed
        frame_start = 1; tick();
        tick(); tick();
        iss_ready = 1; tick(); iss_ready = 0;
        frame_end = 1; tick();
        iss_done = 1; tick(); iss_done = 0;
        tick();
        chk(per_free == CW'(DEPTH), "R6 pop on done", per_free, DEPTH);

        // random mixed traffic
        ds_mode = 2;
        for (int c = 0; c < 3000; c++) begin
            if ($urandom_range(2) == 0) begin
                push_valid = 1; push_periodic = $urandom_range(1);
                push_dir = $urandom_range(1); push_chan = CHAN_W'($urandom);
                push_attr = ATTR_W'($urandom);
            end
            if (c % 50 == 0) frame_start = 1;
            if (c % 50 == 40) frame_end = 1;
            if (c % 97 == 5) begin frame_start = 1; frame_end = 1; end
            if ($urandom_range(19) == 0) incomp_clr = 1;
            tick();
        end
        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule